// File: doc/BRIEF.md
# Two-Child MSI Coherence Controller

This block keeps two child caches coherent on one line slot under a single parent directory. Each child has one slot that holds a tag and an MSI state (I, S or M). A processor-side request on a child port is either a load or a store to a tag. A load hits when the slot holds that tag in S or M. A store hits only in M. Any other request turns into a message exchange with the parent. The parent keeps its own record of every child's state and tag. Before it grants a line, it forces the other child down to a state that does not conflict with the grant.

Every child-to-parent and parent-to-child message sits one cycle in a message register before the receiver consumes it. So no module ever sees a reply in the cycle it sends a request. If a child's slot holds a different tag in S or M, the child first sends the parent an eviction reply that carries write-back when the line was M, and only then sends its upgrade request. A downgrade reply from a child that was in M also raises a write-back pulse at the parent.

Child state machine: `C_IDLE` (accepts a request when no downgrade request is arriving; a hit finishes there), `C_EVICT` (the eviction reply has gone out; the next cycle sends the upgrade), `C_WAITP` (the wait-for-parent flag is up; a grant returns it to `C_IDLE`). Parent state machine: `P_IDLE` (serves the pending request with the highest priority; it grants at once or sends one downgrade and moves to `P_DOWN`), `P_DOWN` (holds until the downgraded child's reply arrives, then returns to `P_IDLE` to check again).

Top module: `msi_pair`

## Requirements
- R1: Reset state: both children and the parent's view show I on every lane, all wait flags are low, cpu_ready is 11 and cpu_done and wb_pulse are 00.
- R2: A hit (a load with a matching tag in S or M, or a store with a matching tag in M) raises cpu_done in the cycle right after the accepting edge and changes no state.
- R3: A load miss, when the other child holds no conflicting copy, completes with the requester in S. cpu_done shows 4 sampled cycles after acceptance, counting the one right after the accepting edge as 1. The same holds for a store miss or an S-to-M upgrade with no sharer, which ends in M.
- R4: A load to a tag the other child holds in M makes the parent downgrade that child to S, and a write-back pulse for that child is raised. The requester reaches S with cpu_done at sample 7.
- R5: A store to a tag the other child holds in S downgrades that child to I without write-back. The requester reaches M with cpu_done at sample 7.
- R6: A request whose tag differs from a slot held in S or M first evicts the slot to I, with a write-back pulse when it was M, and then upgrades for the new tag. cpu_done shows at sample 5 when the other child does not conflict.
- R7: Two children never hold the same tag with one of them in M and the other not in I.
- R8: While a child's wait-for-parent flag is set, its cpu_ready is low and it sends no new upgrade request.
- R9: The parent's wait-for-child flag is up from the cycle after it sends a downgrade request until the cycle after the reply is consumed. No second downgrade request goes to that child while the flag is up.
- R10: When both children have requests pending, child 0 is served first. Two sharers that store to the same tag at the same edge finish at samples 7 (child 0) and 11 (child 1). Child 1 ends in M, child 0 in I, and child 0's M copy is written back.
- R11: For a child whose tag equals the parent's recorded tag, the child's state never exceeds the parent's record. Once the block is quiet, the two are equal.
- R12: State encoding on every 2-bit lane: I=0, S=1, M=2. Child c uses bits [2c+1:2c] of state buses and bits [TAG_W*c+TAG_W-1:TAG_W*c] of tag buses. Bit c of every 2-bit flag bus belongs to child c.
- R13: If a child evicts an M line while the other child loads that same tag at the same edge, the eviction alone clears the conflict and no downgrade is sent. The load finishes at sample 4 and the evicting store at sample 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 2 | Request strobe per child |
| cpu_store | input | 2 | 1 = store (wants M), 0 = load (wants S), per child |
| cpu_tag | input | 2*TAG_W | Requested tag per child |
| cpu_ready | output | 2 | Child can accept a request this cycle |
| cpu_done | output | 2 | One-cycle pulse when a child's request completes |
| child_st | output | 4 | Each child's slot state |
| child_wait | output | 2 | Each child's wait-for-parent flag |
| dir_st | output | 4 | Parent's recorded state for each child |
| dir_wait | output | 2 | Parent's wait-for-child flag per child |
| wb_pulse | output | 2 | Parent absorbed write-back data from that child |

## Verification
Every result has a fixed due time, because each message register adds exactly one cycle. The bench counts samples on falling edges, and sample 1 is the one right after the accepting edge. A hit is due at 1, an uncontended miss at 4, an eviction followed by a grant at 5, a single downgrade round trip at 7, and the second request of a same-edge store race at 11. The bench records the first sample at which cpu_done appears and compares it with these numbers, so early and late completion both fail. The wait-for-child flag is checked at samples 3 and 5 of the load-versus-M case, which bracket the downgrade round trip. Final states are read only after a 24-sample window, when all message traffic has ended.

// File: rtl/msi_pkg.sv
package msi_pkg;
    typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_M = 2'd2} mst_t;
    typedef enum logic [1:0] {C_IDLE = 2'd0, C_EVICT = 2'd1, C_WAITP = 2'd2} cst_t;
    typedef enum logic {P_IDLE = 1'b0, P_DOWN = 1'b1} pst_t;
endpackage

// File: rtl/msi_child.sv
module msi_child
    import msi_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_valid,
    input  logic             cpu_store,
    input  logic [TAG_W-1:0] cpu_tag,
    output logic             cpu_ready,
    output logic             cpu_done,
    input  logic             grant_v,
    input  logic [1:0]       grant_st,
    input  logic             dreq_v,
    input  logic [1:0]       dreq_st,
    input  logic [TAG_W-1:0] dreq_tag,
    output logic             up_v,
    output logic [1:0]       up_want,
    output logic [TAG_W-1:0] up_tag,
    output logic             dn_v,
    output logic [1:0]       dn_st,
    output logic             dn_dirty,
    output logic             dn_evict,
    output logic [1:0]       st,
    output logic [TAG_W-1:0] tag,
    output logic             waitp
);
    cst_t             cst_q, cst_d;
    mst_t             st_q;
    logic [TAG_W-1:0] tag_q, ptag_q;
    logic             pstore_q;
    logic             accept, hit, must_evict, dtag_match;

    assign cpu_ready  = (cst_q == C_IDLE) && !dreq_v;
    assign accept     = cpu_valid && cpu_ready;
    assign hit        = (cpu_tag == tag_q) && (cpu_store ? (st_q == ST_M) : (st_q != ST_I));
    assign must_evict = (cpu_tag != tag_q) && (st_q != ST_I);
    assign dtag_match = (dreq_tag == tag_q);
    assign st         = st_q;
    assign tag        = tag_q;
    assign waitp      = (cst_q == C_WAITP);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) cst_q <= C_IDLE;
        else        cst_q <= cst_d;
    end

    // Next state
    always_comb begin
        cst_d = cst_q;
        unique case (cst_q)
            C_IDLE:  if (accept && !hit) cst_d = must_evict ? C_EVICT : C_WAITP;
            C_EVICT: cst_d = C_WAITP;
            C_WAITP: if (grant_v) cst_d = C_IDLE;
            default: cst_d = C_IDLE;
        endcase
    end

    // Slot contents and outgoing messages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_I;
            tag_q    <= '0;
            ptag_q   <= '0;
            pstore_q <= 1'b0;
            up_v     <= 1'b0;
            up_want  <= 2'd0;
            up_tag   <= '0;
            dn_v     <= 1'b0;
            dn_st    <= 2'd0;
            dn_dirty <= 1'b0;
            dn_evict <= 1'b0;
            cpu_done <= 1'b0;
        end else begin
            up_v     <= 1'b0;
            dn_v     <= 1'b0;
            cpu_done <= 1'b0;
            if (dreq_v) begin
                dn_v     <= 1'b1;
                dn_evict <= 1'b0;
                if (dtag_match && (st_q > mst_t'(dreq_st))) begin
                    st_q     <= mst_t'(dreq_st);
                    dn_st    <= dreq_st;
                    dn_dirty <= (st_q == ST_M);
                end else begin
                    dn_st    <= dtag_match ? st_q : ST_I;
                    dn_dirty <= 1'b0;
                end
            end
            unique case (cst_q)
                C_IDLE: begin
                    if (accept) begin
                        if (hit) begin
                            cpu_done <= 1'b1;
                        end else if (must_evict) begin
                            dn_v     <= 1'b1;
                            dn_st    <= ST_I;
                            dn_dirty <= (st_q == ST_M);
                            dn_evict <= 1'b1;
                            st_q     <= ST_I;
                            pstore_q <= cpu_store;
                            ptag_q   <= cpu_tag;
                        end else begin
                            up_v    <= 1'b1;
                            up_want <= cpu_store ? ST_M : ST_S;
                            up_tag  <= cpu_tag;
                            tag_q   <= cpu_tag;
                        end
                    end
                end
                C_EVICT: begin
                    up_v    <= 1'b1;
                    up_want <= pstore_q ? ST_M : ST_S;
                    up_tag  <= ptag_q;
                    tag_q   <= ptag_q;
                end
                C_WAITP: begin
                    if (grant_v) begin
                        st_q     <= mst_t'(grant_st);
                        cpu_done <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/msi_parent.sv
module msi_parent
    import msi_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         up_v,
    input  logic [3:0]         up_want,
    input  logic [2*TAG_W-1:0] up_tag,
    input  logic [1:0]         dn_v,
    input  logic [3:0]         dn_st,
    input  logic [1:0]         dn_dirty,
    input  logic [1:0]         dn_evict,
    output logic [1:0]         grant_v,
    output logic [3:0]         grant_st,
    output logic [1:0]         dreq_v,
    output logic [3:0]         dreq_st,
    output logic [2*TAG_W-1:0] dreq_tag,
    output logic [3:0]         dir_st,
    output logic [2*TAG_W-1:0] dir_tag,
    output logic [1:0]         dir_wait,
    output logic [1:0]         wb_pulse
);
    pst_t             ps_q, ps_d;
    mst_t             vst_q  [2];
    logic [TAG_W-1:0] vtag_q [2];
    logic [1:0]       pend_v_q;
    logic [1:0]       pwant_q [2];
    logic [TAG_W-1:0] ptag_q  [2];
    logic             cur_q, sel, oth, oq, anypend, conflict, other_back;
    mst_t             want, target;
    logic [TAG_W-1:0] rtag;

    assign anypend    = |pend_v_q;
    assign sel        = pend_v_q[0] ? 1'b0 : 1'b1;
    assign oth        = ~sel;
    assign want       = mst_t'(pwant_q[sel]);
    assign rtag       = ptag_q[sel];
    assign target     = (want == ST_M) ? ST_I : ST_S;
    assign conflict   = (vtag_q[oth] == rtag) &&
                        ((want == ST_M) ? (vst_q[oth] != ST_I) : (vst_q[oth] == ST_M));
    assign oq         = ~cur_q;
    assign other_back = dn_v[oq] && !dn_evict[oq];

    for (genvar c = 0; c < 2; c++) begin : g_view
        assign dir_st[2*c +: 2]          = vst_q[c];
        assign dir_tag[TAG_W*c +: TAG_W] = vtag_q[c];
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) ps_q <= P_IDLE;
        else        ps_q <= ps_d;
    end

    // Next state
    always_comb begin
        ps_d = ps_q;
        unique case (ps_q)
            P_IDLE: if (anypend && conflict) ps_d = P_DOWN;
            P_DOWN: if (other_back) ps_d = P_IDLE;
            default: ps_d = P_IDLE;
        endcase
    end

    // Directory view, pending requests and outgoing messages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                vst_q[c]   <= ST_I;
                vtag_q[c]  <= '0;
                pwant_q[c] <= 2'd0;
                ptag_q[c]  <= '0;
            end
            pend_v_q <= 2'b00;
            dir_wait <= 2'b00;
            cur_q    <= 1'b0;
            grant_v  <= 2'b00;
            grant_st <= 4'd0;
            dreq_v   <= 2'b00;
            dreq_st  <= 4'd0;
            dreq_tag <= '0;
            wb_pulse <= 2'b00;
        end else begin
            grant_v  <= 2'b00;
            dreq_v   <= 2'b00;
            wb_pulse <= 2'b00;
            for (int c = 0; c < 2; c++) begin
                if (up_v[c]) begin
                    pend_v_q[c] <= 1'b1;
                    pwant_q[c]  <= up_want[2*c +: 2];
                    ptag_q[c]   <= up_tag[TAG_W*c +: TAG_W];
                end
                if (dn_v[c]) begin
                    vst_q[c]    <= mst_t'(dn_st[2*c +: 2]);
                    wb_pulse[c] <= dn_dirty[c];
                    if (!dn_evict[c]) dir_wait[c] <= 1'b0;
                end
            end
            if (ps_q == P_IDLE && anypend) begin
                if (conflict) begin
                    cur_q                      <= sel;
                    dreq_v[oth]                <= 1'b1;
                    dreq_st[2*oth +: 2]        <= target;
                    dreq_tag[TAG_W*oth +: TAG_W] <= rtag;
                    dir_wait[oth]              <= 1'b1;
                end else begin
                    grant_v[sel]         <= 1'b1;
                    grant_st[2*sel +: 2] <= want;
                    vst_q[sel]           <= want;
                    vtag_q[sel]          <= rtag;
                    pend_v_q[sel]        <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/msi_pair.sv
module msi_pair #(
    parameter int TAG_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         cpu_valid,
    input  logic [1:0]         cpu_store,
    input  logic [2*TAG_W-1:0] cpu_tag,
    output logic [1:0]         cpu_ready,
    output logic [1:0]         cpu_done,
    output logic [3:0]         child_st,
    output logic [1:0]         child_wait,
    output logic [3:0]         dir_st,
    output logic [1:0]         dir_wait,
    output logic [1:0]         wb_pulse
);
    logic [1:0]         up_v, dn_v, dn_dirty, dn_evict, grant_v, dreq_v;
    logic [3:0]         up_want, dn_st, grant_st, dreq_st;
    logic [2*TAG_W-1:0] up_tag, dreq_tag, c_tag, d_tag;

    for (genvar c = 0; c < 2; c++) begin : g_child
        msi_child #(.TAG_W(TAG_W)) u_child (
            .clk       (clk),
            .rst_n     (rst_n),
            .cpu_valid (cpu_valid[c]),
            .cpu_store (cpu_store[c]),
            .cpu_tag   (cpu_tag[TAG_W*c +: TAG_W]),
            .cpu_ready (cpu_ready[c]),
            .cpu_done  (cpu_done[c]),
            .grant_v   (grant_v[c]),
            .grant_st  (grant_st[2*c +: 2]),
            .dreq_v    (dreq_v[c]),
            .dreq_st   (dreq_st[2*c +: 2]),
            .dreq_tag  (dreq_tag[TAG_W*c +: TAG_W]),
            .up_v      (up_v[c]),
            .up_want   (up_want[2*c +: 2]),
            .up_tag    (up_tag[TAG_W*c +: TAG_W]),
            .dn_v      (dn_v[c]),
            .dn_st     (dn_st[2*c +: 2]),
            .dn_dirty  (dn_dirty[c]),
            .dn_evict  (dn_evict[c]),
            .st        (child_st[2*c +: 2]),
            .tag       (c_tag[TAG_W*c +: TAG_W]),
            .waitp     (child_wait[c])
        );
    end

    msi_parent #(.TAG_W(TAG_W)) u_parent (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_v     (up_v),
        .up_want  (up_want),
        .up_tag   (up_tag),
        .dn_v     (dn_v),
        .dn_st    (dn_st),
        .dn_dirty (dn_dirty),
        .dn_evict (dn_evict),
        .grant_v  (grant_v),
        .grant_st (grant_st),
        .dreq_v   (dreq_v),
        .dreq_st  (dreq_st),
        .dreq_tag (dreq_tag),
        .dir_st   (dir_st),
        .dir_tag  (d_tag),
        .dir_wait (dir_wait),
        .wb_pulse (wb_pulse)
    );
endmodule

// File: rtl/msi_check.sv
module msi_check #(
    parameter int TAG_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [3:0]         child_st,
    input logic [2*TAG_W-1:0] c_tag,
    input logic [1:0]         child_wait,
    input logic [3:0]         dir_st,
    input logic [2*TAG_W-1:0] d_tag,
    input logic [1:0]         dir_wait,
    input logic [1:0]         up_v,
    input logic [1:0]         dreq_v,
    input logic [1:0]         grant_v,
    input logic [3:0]         grant_st
);
    for (genvar c = 0; c < 2; c++) begin : g_chk
        localparam int O = 1 - c;

        a_r7_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
            (child_st[2*c +: 2] == 2'd2 && c_tag[TAG_W*c +: TAG_W] == c_tag[TAG_W*O +: TAG_W])
            |-> child_st[2*O +: 2] == 2'd0);

        a_r8_no_reissue: assert property (@(posedge clk) disable iff (!rst_n)
            up_v[c] |-> !$past(child_wait[c]));

        a_r9_no_dup_dreq: assert property (@(posedge clk) disable iff (!rst_n)
            dreq_v[c] |-> !$past(dir_wait[c]));

        a_r5_m_grant_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
            (grant_v[c] && grant_st[2*c +: 2] == 2'd2)
            |-> (dir_st[2*O +: 2] == 2'd0 || d_tag[TAG_W*O +: TAG_W] != d_tag[TAG_W*c +: TAG_W]));

        a_r11_view_covers: assert property (@(posedge clk) disable iff (!rst_n)
            (c_tag[TAG_W*c +: TAG_W] == d_tag[TAG_W*c +: TAG_W])
            |-> child_st[2*c +: 2] <= dir_st[2*c +: 2]);
    end
endmodule

bind msi_pair msi_check #(.TAG_W(TAG_W)) u_msi_check (
    .clk        (clk),
    .rst_n      (rst_n),
    .child_st   (child_st),
    .c_tag      (c_tag),
    .child_wait (child_wait),
    .dir_st     (dir_st),
    .d_tag      (d_tag),
    .dir_wait   (dir_wait),
    .up_v       (up_v),
    .dreq_v     (dreq_v),
    .grant_v    (grant_v),
    .grant_st   (grant_st)
);

// File: tb/tb_msi_pair.sv
`timescale 1ns/1ps
module tb_msi_pair;
    localparam int TW = 4;
    localparam int WIN = 24;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      cpu_valid = 2'b00, cpu_store = 2'b00;
    logic [2*TW-1:0] cpu_tag = '0;
    logic [1:0]      cpu_ready, cpu_done, child_wait, dir_wait, wb_pulse;
    logic [3:0]      child_st, dir_st;

    int         tests = 0, fails = 0;
    int         lat0, lat1;
    logic [1:0] wbs;
    logic       rbad;
    logic [1:0] dwk [1:WIN];
    logic [1:0] cwk [1:WIN];

    always #4 clk = ~clk;

    msi_pair #(.TAG_W(TW)) dut (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_store(cpu_store),
        .cpu_tag(cpu_tag), .cpu_ready(cpu_ready), .cpu_done(cpu_done),
        .child_st(child_st), .child_wait(child_wait), .dir_st(dir_st),
        .dir_wait(dir_wait), .wb_pulse(wb_pulse)
    );

    task automatic chk(input string r, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cpu_valid = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Issue on the masked children at one edge, then watch WIN samples.
    task automatic go(input logic [1:0] m, input logic s0, input int t0,
                      input logic s1, input int t1);
        @(negedge clk);
        cpu_valid = m;
        cpu_store = {s1, s0};
        cpu_tag   = {t1[TW-1:0], t0[TW-1:0]};
        @(posedge clk);
        @(negedge clk);
        cpu_valid = 2'b00;
        lat0 = 0; lat1 = 0; wbs = 2'b00; rbad = 1'b0;
        for (int k = 1; k <= WIN; k++) begin
            if (k > 1) @(negedge clk);
            wbs |= wb_pulse;
            if (m[0] && lat0 == 0) begin
                if (cpu_done[0]) lat0 = k;
                else if (cpu_ready[0]) rbad = 1'b1;
            end
            if (m[1] && lat1 == 0) begin
                if (cpu_done[1]) lat1 = k;
                else if (cpu_ready[1]) rbad = 1'b1;
            end
            dwk[k] = dir_wait;
            cwk[k] = child_wait;
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 child_st", child_st, 0);
        chk("R1 dir_st", dir_st, 0);
        chk("R1 waits", {child_wait, dir_wait}, 0);
        chk("R1 ready", cpu_ready, 3);
        chk("R1 done/wb", {cpu_done, wb_pulse}, 0);
    endtask

    task automatic t_load_miss_and_hit();
        do_reset();
        go(2'b01, 1'b0, 3, 1'b0, 0);
        chk("R3 load latency", lat0, 4);
        chk("R8 wait flag at sample 1", cwk[1], 2'b01);
        chk("R8 ready low while waiting", rbad, 0);
        chk("R12 child_st lane0=S", child_st, 4'b0001);
        chk("R11 dir view equal", dir_st, 4'b0001);
        go(2'b01, 1'b0, 3, 1'b0, 0);
        chk("R2 load hit latency", lat0, 1);
        chk("R2 hit no change", dir_st, 4'b0001);
        go(2'b01, 1'b1, 3, 1'b0, 0);
        chk("R3 upgrade no sharer latency", lat0, 4);
        chk("R3 upgrade to M", child_st, 4'b0010);
    endtask

    task automatic t_load_vs_m();
        do_reset();
        go(2'b10, 1'b0, 0, 1'b1, 5);
        chk("R3 store miss latency", lat1, 4);
        go(2'b01, 1'b0, 5, 1'b0, 0);
        chk("R4 latency", lat0, 7);
        chk("R4 writeback from child1", wbs, 2'b10);
        chk("R9 waitc up at sample 3", dwk[3], 2'b10);
        chk("R9 waitc down at sample 5", dwk[5], 2'b00);
        chk("R4 both S", child_st, 4'b0101);
        chk("R11 view after R4", dir_st, 4'b0101);
    endtask

    task automatic t_store_vs_s();
        do_reset();
        go(2'b01, 1'b0, 7, 1'b0, 0);
        go(2'b10, 1'b0, 0, 1'b0, 7);
        chk("R3 second sharer latency", lat1, 4);
        go(2'b10, 1'b0, 0, 1'b1, 7);
        chk("R5 latency", lat1, 7);
        chk("R5 no writeback", wbs, 2'b00);
        chk("R7 child1 M child0 I", child_st, 4'b1000);
        go(2'b10, 1'b0, 0, 1'b1, 7);
        chk("R2 store hit latency", lat1, 1);
    endtask

    task automatic t_evict();
        do_reset();
        go(2'b01, 1'b1, 2, 1'b0, 0);
        go(2'b01, 1'b1, 9, 1'b0, 0);
        chk("R6 latency", lat0, 5);
        chk("R6 writeback child0", wbs, 2'b01);
        chk("R6 child0 M", child_st, 4'b0010);
        chk("R11 dir after evict", dir_st, 4'b0010);
    endtask

    task automatic t_race();
        do_reset();
        go(2'b01, 1'b0, 4, 1'b0, 0);
        go(2'b10, 1'b0, 0, 1'b0, 4);
        go(2'b11, 1'b1, 4, 1'b1, 4);
        chk("R10 child0 latency", lat0, 7);
        chk("R10 child1 latency", lat1, 11);
        chk("R10 writeback child0 only", wbs, 2'b01);
        chk("R10 final child states", child_st, 4'b1000);
        chk("R11 final dir states", dir_st, 4'b1000);
        chk("R8 ready low in race", rbad, 0);
    endtask

    task automatic t_cross();
        do_reset();
        go(2'b10, 1'b0, 0, 1'b1, 5);
        go(2'b11, 1'b0, 5, 1'b1, 11);
        chk("R13 load latency", lat0, 4);
        chk("R13 evicting store latency", lat1, 5);
        chk("R13 no downgrade sent", dwk[2] | dwk[3], 2'b00);
        chk("R13 writeback child1", wbs, 2'b10);
        chk("R7 final states", child_st, 4'b1001);
    endtask

    initial begin
        #(200000 * 8);
        tests++;
        fails++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_load_miss_and_hit();
        t_load_vs_m();
        t_store_vs_s();
        t_evict();
        t_race();
        t_cross();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule